// File: doc/BRIEF.md
# Pipelined Byte-Write Static Memory

This block is a single-port synchronous word memory. It has a bidirectional 32-bit data bus made of four 8-bit lanes. Address, write data and every control input are captured on the rising clock edge. A captured write is committed to the storage array on the following edge. A captured read loads an output pipeline register on the following edge, and that register drives the shared bus.

A write can touch any subset of the four lanes. Each lane has its own active-low enable, and those enables count only while a common lane-write strobe is low. A separate full-word write input stores all four lanes whatever the lane enables say. A command with no lane selected is a read.

Three select inputs support depth expansion: two are active high and one is active low. The bus driver is gated at once by an active-low output enable.

A sleep input powers the block down. While it is asleep, commands are dropped and the contents are kept. After sleep is released, a fixed wake-up window must pass before commands are accepted again. The default build holds 1024 words; the full 32K-word organization is obtained by setting `DEPTH` to 32768.

Top module: `sram_pipe_top`

## Requirements
- R1: After synchronous reset the output register holds zero, the block is awake, and no command is pending. With `out_en_n` low the bus then reads 0.
- R2: A read sampled at edge N changes the bus value only after edge N+1. Between edges N and N+1 the bus still shows the previous output register value.
- R3: With `all_wr_n` high and `byte_wr_n` low, a low `lane_en_n[i]` writes bits 8i+7..8i only. Lane 0 is bits 7:0 and lane 3 is bits 31:24. Unselected lanes keep their contents.
- R4: With `all_wr_n` and `byte_wr_n` both high, the lane enables have no effect and the command is a read.
- R5: A low `all_wr_n` writes all 32 bits, whatever the values of `byte_wr_n` and `lane_en_n`.
- R6: A read of an address that is presented in the cycle right after a write to the same address returns the newly written data.
- R7: A command is accepted only when `sel_a`=1, `sel_b`=1 and `sel_n`=0. Otherwise nothing is written and the output register keeps its value.
- R8: `out_en_n` acts on the bus without waiting for a clock edge. High means high impedance; low means the output register is driven.
- R9: A command sampled while `sleep` is high is dropped and the memory contents are kept. The bus is high impedance while `sleep` is high or the block is not awake.
- R10: Take the first edge that samples `sleep` low after power-down. Commands sampled at that edge and at the next three edges are dropped. The first command accepted is the one sampled at the fourth edge after it.
- R11: If `sleep` is sampled high during the wake-up window, the block returns to power-down. The full window then restarts on the next release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, sampled on the clock edge |
| sel_a | input | 1 | Select, active high |
| sel_b | input | 1 | Select, active high |
| sel_n | input | 1 | Select, active low |
| all_wr_n | input | 1 | Full-word write, active low |
| byte_wr_n | input | 1 | Lane-write strobe, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low, bit i = lane i |
| out_en_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Power-down request, active high |
| dq | inout | 32 | Shared data bus: write data in, read data out |

## Verification
On every cycle, the assertions check the following. A sampled sleep or a missing select blocks the captured command. A full-word write yields a four-lane mask. Lane enables without a strobe never form a write. The output register moves only on an accepted read. Every return to the awake state follows exactly the configured number of wake-up cycles, and sleep during wake-up falls back to power-down. The bench scenarios are what show data integrity: lane isolation, write-then-read ordering, contents surviving power-down, the exact command that is first accepted after wake-up, and the bus falling to high impedance within a cycle on the output enable.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        PW_RUN  = 2'd0,
        PW_DOWN = 2'd1,
        PW_WAKE = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [LANES-1:0] mask;
    } op_t;

    // Lanes to be written; zero means the command is a read.
    function automatic logic [LANES-1:0] lane_mask(
        input logic             all_wr_n,
        input logic             byte_wr_n,
        input logic [LANES-1:0] lane_en_n
    );
        if (!all_wr_n)
            return '1;
        else if (!byte_wr_n)
            return ~lane_en_n;
        else
            return '0;
    endfunction

    function automatic logic chip_selected(
        input logic sel_a,
        input logic sel_b,
        input logic sel_n
    );
        return sel_a & sel_b & ~sel_n;
    endfunction

endpackage

// File: rtl/sram_pwr_ctrl.sv
`timescale 1ns/1ps
module sram_pwr_ctrl
    import sram_pkg::*;
#(
    parameter int WAKE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep,
    output logic run_o
);

    localparam int CNT_W = $clog2(WAKE_CYC + 1);

    pwr_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PW_RUN;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                PW_RUN: begin
                    if (sleep) state_q <= PW_DOWN;
                end
                PW_DOWN: begin
                    if (!sleep) begin
                        state_q <= PW_WAKE;
                        cnt_q   <= CNT_W'(WAKE_CYC - 1);
                    end
                end
                PW_WAKE: begin
                    if (sleep)
                        state_q <= PW_DOWN;
                    else if (cnt_q == '0)
                        state_q <= PW_RUN;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                default: state_q <= PW_DOWN;
            endcase
        end
    end

    assign run_o = (state_q == PW_RUN);

    // Independent tally of consecutive wake cycles.
    logic [CNT_W:0] wake_seen_q;
    always_ff @(posedge clk) begin
        if (rst)
            wake_seen_q <= '0;
        else if (state_q == PW_WAKE)
            wake_seen_q <= wake_seen_q + 1'b1;
        else
            wake_seen_q <= '0;
    end

    // R10
    wake_window_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_RUN && $past(state_q) == PW_WAKE) |-> wake_seen_q == (CNT_W+1)'(WAKE_CYC));

    // R11
    rewake_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_WAKE && sleep) |=> state_q == PW_DOWN);

endmodule

// File: rtl/sram_cmd_reg.sv
`timescale 1ns/1ps
module sram_cmd_reg
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              sleep,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_n,
    input  logic              all_wr_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output op_t               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o
);

    logic             accept;
    logic [LANES-1:0] mask_w;
    op_t              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    assign accept = run & ~sleep & chip_selected(sel_a, sel_b, sel_n);
    assign mask_w = lane_mask(all_wr_n, byte_wr_n, lane_en_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else begin
            op_q.vld  <= accept;
            op_q.wr   <= |mask_w;
            op_q.mask <= mask_w;
        end
    end

    always_ff @(posedge clk) begin
        addr_q  <= addr;
        wdata_q <= wdata;
    end

    assign op_o    = op_q;
    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;

    // R9
    sleep_blocks_op_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !op_q.vld);

    // R7
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_a || !sel_b || sel_n) |=> !op_q.vld);

    // R5
    global_write_chk: assert property (@(posedge clk) disable iff (rst)
        !all_wr_n |=> (op_q.wr && op_q.mask == '1));

    // R4
    lanes_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (all_wr_n && byte_wr_n) |=> !op_q.wr);

endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array
    import sram_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[g])
                lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[addr];
    end

endmodule

// File: rtl/sram_out_pipe.sv
`timescale 1ns/1ps
module sram_out_pipe
    import sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    input  logic              out_en_n,
    input  logic              asleep,
    output logic [WORD_W-1:0] q_o,
    output logic              drive_o
);

    logic [WORD_W-1:0] q_q;

    always_ff @(posedge clk) begin
        if (rst)
            q_q <= '0;
        else if (load)
            q_q <= din;
    end

    assign q_o     = q_q;
    assign drive_o = ~out_en_n & ~asleep;

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q_q));

    // R2
    read_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> q_q == $past(din));

endmodule

// File: rtl/sram_pipe_top.sv
`timescale 1ns/1ps
module sram_pipe_top
    import sram_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int WAKE_CYC = 3,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_n,
    input  logic              all_wr_n,
    input  logic              byte_wr_n,
    input  logic [3:0]        lane_en_n,
    input  logic              out_en_n,
    input  logic              sleep,
    inout  wire  [31:0]       dq
);

    logic              run;
    op_t               op;
    logic [ADDR_W-1:0] op_addr;
    logic [WORD_W-1:0] op_wdata;
    logic [WORD_W-1:0] rdata;
    logic [WORD_W-1:0] q;
    logic              drive;

    sram_pwr_ctrl #(.WAKE_CYC(WAKE_CYC)) pwr_i (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .run_o (run)
    );

    sram_cmd_reg #(.ADDR_W(ADDR_W)) cmd_i (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .sleep     (sleep),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_n     (sel_n),
        .all_wr_n  (all_wr_n),
        .byte_wr_n (byte_wr_n),
        .lane_en_n (lane_en_n),
        .addr      (addr),
        .wdata     (dq),
        .op_o      (op),
        .addr_o    (op_addr),
        .wdata_o   (op_wdata)
    );

    sram_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) array_i (
        .clk   (clk),
        .we    (op.vld & op.wr),
        .mask  (op.mask),
        .addr  (op_addr),
        .wdata (op_wdata),
        .rdata (rdata)
    );

    sram_out_pipe out_i (
        .clk      (clk),
        .rst      (rst),
        .load     (op.vld & ~op.wr),
        .din      (rdata),
        .out_en_n (out_en_n),
        .asleep   (sleep | ~run),
        .q_o      (q),
        .drive_o  (drive)
    );

    assign dq = drive ? q : 'z;

endmodule

// File: tb/sram_pipe_top_tb.sv
`timescale 1ns/1ps
module sram_pipe_top_tb_top;

    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [31:0] FLOAT = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          sel_a, sel_b, sel_n;
    logic          all_wr_n, byte_wr_n;
    logic [3:0]    lane_en_n;
    logic          out_en_n, sleep;
    logic          tb_drv;
    logic [31:0]   tb_data;
    wire  [31:0]   dq;

    assign dq = tb_drv ? tb_data : 'z;
    for (genvar b = 0; b < 32; b++) begin : g_pu
        pullup (dq[b]);
    end

    always #4 clk = ~clk;

    sram_pipe_top #(.DEPTH(DEPTH), .WAKE_CYC(3)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_n     (sel_n),
        .all_wr_n  (all_wr_n),
        .byte_wr_n (byte_wr_n),
        .lane_en_n (lane_en_n),
        .out_en_n  (out_en_n),
        .sleep     (sleep),
        .dq        (dq)
    );

    int          checks = 0;
    int          errors = 0;
    logic [31:0] model [DEPTH];
    logic [31:0] last_q;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fill_val(input int a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h25A5_0000;
    endfunction

    function automatic logic [3:0] exp_lanes(input logic aw_n, input logic bw_n, input logic [3:0] le_n);
        if (!aw_n) return 4'hF;
        if (!bw_n) return ~le_n;
        return 4'h0;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++)
            if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        sel_a = 1'b0; sel_b = 1'b1; sel_n = 1'b0;
        all_wr_n = 1'b1; byte_wr_n = 1'b1; lane_en_n = 4'hF;
        tb_drv = 1'b0;
    endtask

    // Present one command for one cycle; the model is updated by the caller's intent.
    task automatic write_op(input int a, input logic [31:0] d, input logic aw_n,
                            input logic bw_n, input logic [3:0] le_n, input logic upd);
        logic [3:0] m;
        sel_a = 1'b1; sel_b = 1'b1; sel_n = 1'b0;
        addr = AW'(a); all_wr_n = aw_n; byte_wr_n = bw_n; lane_en_n = le_n;
        out_en_n = 1'b1; tb_drv = 1'b1; tb_data = d;
        tick();
        m = exp_lanes(aw_n, bw_n, le_n);
        if (upd) begin
            if (m != 4'h0) model[a] = merge(model[a], d, m);
            else           last_q   = model[a];
        end
    endtask

    task automatic read_chk(input int a, input string tag);
        sel_a = 1'b1; sel_b = 1'b1; sel_n = 1'b0;
        addr = AW'(a); all_wr_n = 1'b1; byte_wr_n = 1'b1; lane_en_n = 4'h0;
        out_en_n = 1'b0; tb_drv = 1'b0;
        tick();
        chk("R2 bus unchanged one edge after read sample", dq, last_q);
        idle();
        tick();
        chk(tag, dq, model[a]);
        last_q = model[a];
    endtask

    // Deselected command: v selects which select input is wrong.
    task automatic desel_op(input int v, input int a, input logic wr, input logic [31:0] d);
        sel_a = (v != 0); sel_b = (v != 1); sel_n = (v == 2);
        addr = AW'(a); all_wr_n = ~wr; byte_wr_n = 1'b1; lane_en_n = 4'hF;
        out_en_n = wr; tb_drv = wr; tb_data = d;
        tick();
        if (!wr) chk("R7 output held on deselected read", dq, last_q);
        idle();
        out_en_n = 1'b0;
        tick();
        chk("R7 output held after deselected command", dq, last_q);
    endtask

    // Release sleep and write base+k for k = 0..4 in consecutive cycles.
    task automatic wake_probe(input int base);
        sleep = 1'b0;
        for (int k = 0; k < 5; k++)
            write_op(base + k, 32'hC0DE_0000 | 32'(k), 1'b0, 1'b1, 4'hF, (k == 4));
        idle();
        tick();
        tick();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; sleep = 1'b0; out_en_n = 1'b1; addr = '0; tb_data = '0;
        idle();
        last_q = 32'h0;
        repeat (3) @(posedge clk);
        tick();
        rst = 1'b0;
        // R1: reset state
        out_en_n = 1'b0;
        #1 chk("R1 output register zero after reset", dq, 32'h0);
        out_en_n = 1'b1;
        #1 chk("R8 bus floats with output enable high", dq, FLOAT);
        tick();

        // Fill with full-word writes (R5 path), lane enables randomised
        void'($urandom(32'd20240611));
        for (int a = 0; a < DEPTH; a++)
            write_op(a, fill_val(a), 1'b0, 1'($urandom % 2), 4'($urandom), 1'b1);
        idle();
        tick();
        read_chk(0, "R5 full-word fill readback");
        read_chk(DEPTH - 1, "R5 full-word fill readback top address");

        // R3: each lane alone
        for (int i = 0; i < 4; i++) begin
            write_op(10, 32'h1111_1111 * 32'(i + 3), 1'b1, 1'b0, ~(4'b1 << i), 1'b1);
            read_chk(10, "R3 single lane write");
        end
        write_op(11, 32'hA1B2_C3D4, 1'b1, 1'b0, 4'b1010, 1'b1);
        read_chk(11, "R3 lanes 0 and 2 write");

        // R4: lane enables without strobe do nothing
        write_op(12, 32'h0BAD_0BAD, 1'b1, 1'b1, 4'h0, 1'b1);
        read_chk(12, "R4 lane enables ignored without strobe");

        // R5: full write overrides lane enables
        write_op(13, 32'h7654_3210, 1'b0, 1'b0, 4'b1110, 1'b1);
        read_chk(13, "R5 full-word write overrides lane enables");

        // R6: write then read next cycle
        write_op(14, 32'h5EED_F00D, 1'b0, 1'b1, 4'hF, 1'b1);
        read_chk(14, "R6 back-to-back write then read");

        // R7: each deselect variant, write and read
        for (int v = 0; v < 3; v++) begin
            desel_op(v, 20, 1'b1, 32'hDEAD_0000 | 32'(v));
            desel_op(v, 21, 1'b0, 32'h0);
            read_chk(20, "R7 deselected write left memory unchanged");
        end

        // R8: combinational output enable
        read_chk(13, "R8 setup read");
        out_en_n = 1'b0;
        #1 chk("R8 bus driven with output enable low", dq, last_q);
        out_en_n = 1'b1;
        #1 chk("R8 bus floats within the cycle", dq, FLOAT);
        out_en_n = 1'b0;
        #1 chk("R8 bus driven again within the cycle", dq, last_q);
        tick();

        // R9 and R10: power-down then wake-up window
        sleep = 1'b1;
        write_op(105, 32'h5151_5151, 1'b0, 1'b1, 4'hF, 1'b0);
        for (int k = 0; k < 3; k++)
            write_op(106 + k, 32'h6262_6262, 1'b0, 1'b1, 4'hF, 1'b0);
        idle();
        out_en_n = 1'b0;
        #1 chk("R9 bus floats while asleep", dq, FLOAT);
        tick();
        wake_probe(100);
        out_en_n = 1'b0;
        #1 chk("R10 bus driven again once awake", dq, last_q);
        for (int k = 0; k < 5; k++)
            read_chk(100 + k, "R10 only the fourth-edge command accepted");
        for (int k = 105; k < 109; k++)
            read_chk(k, "R9 write during sleep dropped");

        // R11: sleep during the wake window restarts it
        sleep = 1'b1;
        idle();
        tick(); tick(); tick();
        sleep = 1'b0;
        tick();
        sleep = 1'b1;
        tick();
        wake_probe(200);
        for (int k = 0; k < 5; k++)
            read_chk(200 + k, "R11 window restarted after re-entering sleep");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op = int'($urandom % 8);
            int a  = int'($urandom % DEPTH);
            logic [31:0] d = $urandom;
            case (op)
                0, 1: write_op(a, d, 1'b0, 1'($urandom % 2), 4'($urandom), 1'b1);
                2:    write_op(a, d, 1'b1, 1'b0, 4'($urandom), 1'b1);
                3, 4, 5: read_chk(a, "R3 random readback");
                6:    desel_op(int'($urandom % 3), a, 1'b1, d);
                default: desel_op(int'($urandom % 3), a, 1'b0, d);
            endcase
        end
        idle();
        tick();
        for (int a = 0; a < 32; a++)
            read_chk(a, "R6 final sweep");

        finish_run();
    end

endmodule